// File: doc/BRIEF.md
# Bernoulli Traffic Source and Latency Sink

This block stands in for one endpoint of a simulated on-chip network. Its source half keeps its own time step, the generator time. It runs one Bernoulli trial for each simulated time step. Each trial that succeeds emits a multi-flit packet on a valid/ready output stream. Every flit of that packet carries the destination address and the time step of the trial that created it. Its sink half takes flits from an input stream. When the last flit of a packet arrives, the sink counts the packet and adds its latency to a running total. The latency is the current simulation time minus the injection time carried in the flit.

The global simulation time arrives as a plain input. The generator time trails it, and each idle cycle runs one trial, until the generator time equals the global time. While a packet waits on the output (ready low), the generator time holds its value. The trials that fall due in that period are run later. This models a source queue with no size limit. Output stream rules: out_valid stays high and out_flit is held until a cycle in which out_ready is high. A flit moves on every clock edge where both are high. The input stream never back-pressures: in_ready is always high, so any flit with in_valid high is taken on that edge.

Flit layout for TS_W=16 and DEST_W=6 (24 bits): bits [15:0] hold the injection time, [21:16] the destination, bit 22 marks the last flit (tail), and bit 23 marks the first flit (head).

Top module: `tgs_endpoint`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, and tx_pkt_count, rx_pkt_count and lat_total are zero.
- R2: Each packet has exactly cfg_pkt_len flits. A value of 0 or 1 is treated as 2. Bit 23 (head) is set on the first flit only, and bit 22 (tail) on the last flit only.
- R3: Every flit of a packet carries, in bits [21:16], the cfg_dest value present when the packet started. In bits [15:0] it carries the generator time of the trial that started it. All flits of one packet share that time.
- R4: With cfg_interval equal to 1, every trial succeeds. Packets follow one another with consecutive injection times, starting from the generator time.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_flit does not change in the next cycle.
- R6: While a packet is stalled on the output, the generator time holds its value. No due trial is lost: the injection times continue in order up to the global time minus one. No trial runs once the generator time equals the global time.
- R7: While cfg_enable is low, no new packet starts, and the generator time follows the global time. After re-enable, no packet carries an injection time from the disabled period.
- R8: tx_pkt_count rises by one on each accepted tail flit. It changes at no other time.
- R9: in_ready is always high. A flit with in_valid high and tail bit 22 set adds one to rx_pkt_count. On the same edge it adds (sim_time - bits[15:0]) modulo 2^16 to lat_total. Non-tail flits, and any flit with in_valid low, change neither.
- R10: The latency wraps modulo 2^16: when the global time has wrapped past the injection time, the short forward distance is added.
- R11: With cfg_interval N greater than 1, a trial succeeds when a 16-bit LFSR value is at most 65535/N. This gives about one success per N trials (350 to 650 packets in 2000 trials for N=4). All injection times lie in the trial window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sim_time | input | TS_W | Global simulation time step |
| cfg_enable | input | 1 | Generator enable |
| cfg_pkt_len | input | LEN_W | Packet length in flits (minimum 2) |
| cfg_dest | input | DEST_W | Destination node address |
| cfg_interval | input | IVL_W | Mean number of steps between packet starts |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Output queue can accept a flit |
| out_flit | output | FLIT_W | Output flit |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Always high: sink never stalls |
| in_flit | input | FLIT_W | Input flit |
| tx_pkt_count | output | CNT_W | Packets fully injected |
| rx_pkt_count | output | CNT_W | Packets received |
| lat_total | output | LAT_W | Sum of received packet latencies |

## Verification
Suppose the generator time went wrong, for example it advanced while a packet was stalled. The first flit after the stall would then show an injection time that skips a value, and the scoreboard catches it at the next handshake. A flit counter that is off shows up within one packet: the head or tail bit appears in the wrong position, or there are too many or too few flits. A wrong latency or count in the sink shows on lat_total or rx_pkt_count one cycle after the tail flit.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

  localparam int RNG_W = 16;

  typedef enum logic [0:0] {
    SRC_IDLE = 1'b0,
    SRC_SEND = 1'b1
  } src_state_e;

  // Maximal-length 16-bit Fibonacci sequence, taps 16/14/13/11.
  function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb};
  endfunction

  // Success bound so that P(value <= bound) is about 1/interval.
  function automatic logic [RNG_W-1:0] rate_bound(input logic [RNG_W-1:0] ivl);
    if (ivl == '0) return '1;
    return {RNG_W{1'b1}} / ivl;
  endfunction

endpackage

// File: rtl/tgs_bernoulli.sv
module tgs_bernoulli #(
  parameter int IVL_W = 8,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [IVL_W-1:0] interval,
  output logic             hit
);
  import tgs_pkg::*;

  logic [RNG_W-1:0] rng_q;
  logic [RNG_W-1:0] bound;

  assign bound = rate_bound(RNG_W'(interval));
  assign hit   = (rng_q <= bound);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng_q <= SEED;
    end else if (advance) begin
      rng_q <= rng_step(rng_q);
    end
  end

endmodule

// File: rtl/tgs_source.sv
module tgs_source #(
  parameter int TS_W   = 16,
  parameter int DEST_W = 6,
  parameter int LEN_W  = 4,
  parameter int CNT_W  = 16,
  localparam int FLIT_W = TS_W + DEST_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   sim_time,
  input  logic              cfg_enable,
  input  logic [LEN_W-1:0]  cfg_pkt_len,
  input  logic [DEST_W-1:0] cfg_dest,
  input  logic              trial_hit,
  output logic              trial_go,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_flit,
  output logic [CNT_W-1:0]  tx_pkt_count
);
  import tgs_pkg::*;

  src_state_e        state_q;
  logic [TS_W-1:0]   gen_time_q;
  logic [TS_W-1:0]   pkt_inj_q;
  logic [DEST_W-1:0] pkt_dest_q;
  logic [LEN_W-1:0]  pkt_last_q;
  logic [LEN_W-1:0]  idx_q;
  logic              behind;
  logic              is_head;
  logic              is_tail;
  logic              xfer;

  assign behind   = (sim_time != gen_time_q);
  assign trial_go = (state_q == SRC_IDLE) && cfg_enable && behind;

  assign is_head   = (idx_q == '0);
  assign is_tail   = (idx_q == pkt_last_q);
  assign out_valid = (state_q == SRC_SEND);
  assign out_flit  = {is_head, is_tail, pkt_dest_q, pkt_inj_q};
  assign xfer      = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SRC_IDLE;
      gen_time_q   <= '0;
      pkt_inj_q    <= '0;
      pkt_dest_q   <= '0;
      pkt_last_q   <= LEN_W'(1);
      idx_q        <= '0;
      tx_pkt_count <= '0;
    end else begin
      unique case (state_q)
        SRC_IDLE: begin
          if (!cfg_enable) begin
            gen_time_q <= sim_time;
          end else if (trial_go) begin
            gen_time_q <= gen_time_q + TS_W'(1);
            if (trial_hit) begin
              state_q    <= SRC_SEND;
              pkt_inj_q  <= gen_time_q;
              pkt_dest_q <= cfg_dest;
              idx_q      <= '0;
              pkt_last_q <= (cfg_pkt_len < LEN_W'(2)) ? LEN_W'(1)
                                                      : cfg_pkt_len - LEN_W'(1);
            end
          end
        end
        SRC_SEND: begin
          if (xfer) begin
            if (is_tail) begin
              state_q      <= SRC_IDLE;
              tx_pkt_count <= tx_pkt_count + CNT_W'(1);
            end else begin
              idx_q <= idx_q + LEN_W'(1);
            end
          end
        end
        default: state_q <= SRC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tgs_sink.sv
module tgs_sink #(
  parameter int TS_W  = 16,
  parameter int CNT_W = 16,
  parameter int LAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  sim_time,
  input  logic             flit_valid,
  input  logic             flit_tail,
  input  logic [TS_W-1:0]  flit_inj,
  output logic [CNT_W-1:0] rx_pkt_count,
  output logic [LAT_W-1:0] lat_total
);
  logic [TS_W-1:0] age;

  assign age = sim_time - flit_inj;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pkt_count <= '0;
      lat_total    <= '0;
    end else if (flit_valid && flit_tail) begin
      rx_pkt_count <= rx_pkt_count + CNT_W'(1);
      lat_total    <= lat_total + LAT_W'(age);
    end
  end

endmodule

// File: rtl/tgs_endpoint.sv
module tgs_endpoint #(
  parameter int TS_W   = 16,
  parameter int DEST_W = 6,
  parameter int LEN_W  = 4,
  parameter int IVL_W  = 8,
  parameter int CNT_W  = 16,
  parameter int LAT_W  = 32,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int FLIT_W = TS_W + DEST_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   sim_time,
  input  logic              cfg_enable,
  input  logic [LEN_W-1:0]  cfg_pkt_len,
  input  logic [DEST_W-1:0] cfg_dest,
  input  logic [IVL_W-1:0]  cfg_interval,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_flit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_flit,
  output logic [CNT_W-1:0]  tx_pkt_count,
  output logic [CNT_W-1:0]  rx_pkt_count,
  output logic [LAT_W-1:0]  lat_total
);
  localparam int TAIL_BIT = TS_W + DEST_W;

  logic trial_go;
  logic trial_hit;
  logic unused_in_bits;

  assign in_ready       = 1'b1;
  assign unused_in_bits = ^{in_flit[FLIT_W-1], in_flit[TAIL_BIT-1:TS_W]};

  tgs_bernoulli #(
    .IVL_W (IVL_W),
    .SEED  (SEED)
  ) u_trial (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (trial_go),
    .interval (cfg_interval),
    .hit      (trial_hit)
  );

  tgs_source #(
    .TS_W   (TS_W),
    .DEST_W (DEST_W),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W)
  ) u_src (
    .clk          (clk),
    .rst_n        (rst_n),
    .sim_time     (sim_time),
    .cfg_enable   (cfg_enable),
    .cfg_pkt_len  (cfg_pkt_len),
    .cfg_dest     (cfg_dest),
    .trial_hit    (trial_hit),
    .trial_go     (trial_go),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_flit     (out_flit),
    .tx_pkt_count (tx_pkt_count)
  );

  tgs_sink #(
    .TS_W  (TS_W),
    .CNT_W (CNT_W),
    .LAT_W (LAT_W)
  ) u_snk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sim_time     (sim_time),
    .flit_valid   (in_valid),
    .flit_tail    (in_flit[TAIL_BIT]),
    .flit_inj     (in_flit[TS_W-1:0]),
    .rx_pkt_count (rx_pkt_count),
    .lat_total    (lat_total)
  );

endmodule

// File: rtl/tgs_endpoint_chk.sv
module tgs_endpoint_chk #(
  parameter int TS_W   = 16,
  parameter int DEST_W = 6,
  parameter int CNT_W  = 16,
  parameter int LAT_W  = 32,
  localparam int FLIT_W = TS_W + DEST_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FLIT_W-1:0] out_flit,
  input logic              in_valid,
  input logic [FLIT_W-1:0] in_flit,
  input logic [CNT_W-1:0]  tx_pkt_count,
  input logic [CNT_W-1:0]  rx_pkt_count,
  input logic [LAT_W-1:0]  lat_total
);
  localparam int TAIL_BIT = TS_W + DEST_W;

  // R5
  hold_flit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));

  // R3
  same_inj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_flit[TAIL_BIT]) |=>
      (out_valid && out_flit[TS_W-1:0] == $past(out_flit[TS_W-1:0])));

  // R8
  tx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_flit[TAIL_BIT]) |=>
      (tx_pkt_count == $past(tx_pkt_count) + CNT_W'(1)));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready && out_flit[TAIL_BIT]) |=> $stable(tx_pkt_count));

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_flit[TAIL_BIT]) |=> ($stable(rx_pkt_count) && $stable(lat_total)));

  // R9
  rx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_flit[TAIL_BIT]) |=> (rx_pkt_count == $past(rx_pkt_count) + CNT_W'(1)));

  // R7
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !out_valid) |=> !out_valid);

endmodule

bind tgs_endpoint tgs_endpoint_chk #(
  .TS_W   (TS_W),
  .DEST_W (DEST_W),
  .CNT_W  (CNT_W),
  .LAT_W  (LAT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_enable   (cfg_enable),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_flit     (out_flit),
  .in_valid     (in_valid),
  .in_flit      (in_flit),
  .tx_pkt_count (tx_pkt_count),
  .rx_pkt_count (rx_pkt_count),
  .lat_total    (lat_total)
);

// File: tb/tgs_endpoint_tb_top.sv
module tgs_endpoint_tb_top;
  localparam int TS_W = 16, DEST_W = 6, LEN_W = 4, IVL_W = 8, CNT_W = 16, LAT_W = 32;
  localparam int FLIT_W = TS_W + DEST_W + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TS_W-1:0]   sim_time = '0;
  logic              cfg_enable = 1'b0;
  logic [LEN_W-1:0]  cfg_pkt_len = 4'd2;
  logic [DEST_W-1:0] cfg_dest = '0;
  logic [IVL_W-1:0]  cfg_interval = 8'd1;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [FLIT_W-1:0] out_flit;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [FLIT_W-1:0] in_flit = '0;
  logic [CNT_W-1:0]  tx_pkt_count;
  logic [CNT_W-1:0]  rx_pkt_count;
  logic [LAT_W-1:0]  lat_total;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit stat_mode = 0;
  int stat_pkts = 0;
  int stat_lo = 0;
  int stat_hi = 0;
  logic [FLIT_W-1:0] exp_q[$];

  always #2 clk = ~clk;

  tgs_endpoint dut_i (
    .clk (clk), .rst_n (rst_n), .sim_time (sim_time),
    .cfg_enable (cfg_enable), .cfg_pkt_len (cfg_pkt_len), .cfg_dest (cfg_dest),
    .cfg_interval (cfg_interval), .out_valid (out_valid), .out_ready (out_ready),
    .out_flit (out_flit), .in_valid (in_valid), .in_ready (in_ready),
    .in_flit (in_flit), .tx_pkt_count (tx_pkt_count), .rx_pkt_count (rx_pkt_count),
    .lat_total (lat_total)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected flits of one packet.
  task automatic push_pkt(input int inj, input int len, input int dest);
    int n;
    n = (len < 2) ? 2 : len;
    for (int i = 0; i < n; i++)
      exp_q.push_back({(i == 0), (i == n - 1), DEST_W'(dest), TS_W'(inj)});
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input string tag, input int bound);
    int k;
    k = 0;
    while (exp_q.size() != 0 && k < bound) begin
      step(1);
      k++;
    end
    chk({tag, " scoreboard drained"}, exp_q.size(), 0);
    step(6);
  endtask

  // Monitor: compares each accepted flit with the scoreboard head.
  logic              prev_stall = 1'b0;
  logic [FLIT_W-1:0] prev_flit = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!out_valid || out_flit != prev_flit) begin
          errors++;
          $display("FAIL R5 stall hold actual=%h/%0d expected=%h/1", out_flit, out_valid, prev_flit);
        end
      end
      if (out_valid && out_ready) begin
        if (stat_mode) begin
          checks++;
          if (int'(out_flit[TS_W-1:0]) < stat_lo || int'(out_flit[TS_W-1:0]) >= stat_hi) begin
            errors++;
            $display("FAIL R11 inj time actual=%0d expected=[%0d,%0d)", out_flit[TS_W-1:0], stat_lo, stat_hi);
          end
          if (out_flit[TS_W+DEST_W]) stat_pkts++;
        end else begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R6/R7 unexpected flit actual=%h expected=none", out_flit);
          end else begin
            logic [FLIT_W-1:0] e;
            e = exp_q.pop_front();
            if (out_flit != e) begin
              errors++;
              $display("FAIL R2/R3/R4 flit actual=%h expected=%h", out_flit, e);
            end
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_flit  = out_flit;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 tx", tx_pkt_count, 0);
    chk("R1 rx", rx_pkt_count, 0);
    chk("R1 lat", lat_total, 0);

    // R2 R3 R4: interval 1, len 3, back-to-back packets 100..103
    sim_time = 16'd100;
    step(3);
    cfg_dest = 6'd5; cfg_pkt_len = 4'd3; cfg_interval = 8'd1;
    for (int t = 100; t < 104; t++) push_pkt(t, 3, 5);
    sim_time = 16'd104; cfg_enable = 1'b1;
    drain("R4", 200);
    chk("R8 tx after 4 packets", tx_pkt_count, 4);
    chk("R6 idle when caught up", out_valid, 0);

    // R2: length 1 treated as 2
    cfg_pkt_len = 4'd1;
    push_pkt(104, 1, 5); push_pkt(105, 1, 5);
    sim_time = 16'd106;
    drain("R2", 100);
    chk("R8 tx after min-length", tx_pkt_count, 6);

    // R5 R6: stalled output, generator time lags then catches up
    cfg_pkt_len = 4'd2; cfg_dest = 6'd9; out_ready = 1'b0;
    for (int t = 106; t < 114; t++) push_pkt(t, 2, 9);
    sim_time = 16'd114;
    step(15);
    chk("R5 valid during stall", out_valid, 1);
    for (int k = 0; k < 300 && exp_q.size() != 0; k++) begin
      out_ready = ~out_ready;
      step(1);
    end
    out_ready = 1'b1;
    drain("R6", 50);
    chk("R8 tx after stall", tx_pkt_count, 14);

    // R7: disabled, time moves, nothing starts
    cfg_enable = 1'b0;
    for (int t = 115; t <= 150; t++) begin
      sim_time = TS_W'(t);
      step(1);
    end
    chk("R7 no output while disabled", out_valid, 0);
    chk("R7 tx unchanged", tx_pkt_count, 14);
    cfg_enable = 1'b1; cfg_dest = 6'd33;
    step(5);
    chk("R7 no stale trials after enable", out_valid, 0);
    push_pkt(150, 2, 33); push_pkt(151, 2, 33);
    sim_time = 16'd152;
    drain("R7", 100);
    chk("R8 tx after re-enable", tx_pkt_count, 16);

    // R11: interval 4 over 2000 trials
    stat_mode = 1; stat_lo = 152; stat_hi = 2152; stat_pkts = 0;
    cfg_interval = 8'd4;
    sim_time = 16'd2152;
    step(5000);
    chk("R11 idle after window", out_valid, 0);
    checks++;
    if (stat_pkts < 350 || stat_pkts > 650) begin
      errors++;
      $display("FAIL R11 packet count actual=%0d expected=350..650", stat_pkts);
    end
    chk("R8 tx matches observed", tx_pkt_count, 16 + stat_pkts);
    stat_mode = 0;

    // R9 R10: sink
    cfg_enable = 1'b0;
    sim_time = 16'd200;
    in_valid = 1'b1; in_flit = {1'b1, 1'b0, 6'd3, 16'd150};
    step(1);
    chk("R9 body flit rx", rx_pkt_count, 0);
    chk("R9 body flit lat", lat_total, 0);
    in_flit = {1'b0, 1'b1, 6'd3, 16'd150};
    step(1);
    chk("R9 tail rx", rx_pkt_count, 1);
    chk("R9 tail lat", lat_total, 50);
    in_valid = 1'b0;
    step(2);
    chk("R9 invalid ignored rx", rx_pkt_count, 1);
    chk("R9 invalid ignored lat", lat_total, 50);
    sim_time = 16'd5;
    in_valid = 1'b1; in_flit = {1'b1, 1'b1, 6'd7, 16'd65530};
    step(1);
    in_valid = 1'b0;
    chk("R10 wrapped rx", rx_pkt_count, 2);
    chk("R10 wrapped lat", lat_total, 61);
    chk("R9 in_ready", in_ready, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule